// File: doc/BRIEF.md
# Serial Sector Protection Register Engine

This block is the slave-side command engine for the sector protection register of a serial memory. The register holds one byte per sector, four sectors by default. Each byte is either 00h (sector open) or FFh (sector locked). The serial pins are chip select (active low), serial clock, serial data in and serial data out. The serial data out pin has an output-enable, so the pad can be tri-stated. The serial pins are sampled by the block's own system clock through a short synchronizer.

A write starts with a fixed four-byte opcode. The data bytes that follow fill the register from sector 0 upward. When more bytes arrive than there are sectors, the index wraps and older entries are overwritten. The new contents take effect when chip select is released. A read starts with a one-byte opcode and three ignored filler bytes. The register then streams out, sector 0 first, followed by zero bytes once the register is exhausted. Each sector has its own locked and invalid outputs. A sticky flag records that the shared data buffer was overwritten by a write command.

Top module: `spr_spi_prot`

## Requirements
- R1: After reset every register byte is 00h: prot_o and invalid_o are all zero, buf_dirty_o is 0 and so_oe_o is 0.
- R2: The serial interface is SPI mode 0. si_i is sampled on the rising edge of sck_i and so_o changes only after a falling edge. Bytes travel MSB first.
- R3: The write command is the byte sequence 3Dh, 2Ah, 7Fh, FCh. Data bytes after it go to sector 0, 1, 2 and so on. The register outputs do not change until cs_ni goes high.
- R4: If more data bytes are written than there are sectors, data byte k goes to sector k mod NUM_SECT, and the last byte for a sector wins.
- R5: If any opcode byte differs from the expected sequence, the rest of the transaction is ignored: the register is unchanged and so_oe_o stays 0.
- R6: The read command is opcode 32h followed by three filler bytes of any value. The following bytes return sectors 0 to NUM_SECT-1 in order, and every byte after that is 00h.
- R7: so_oe_o is 1 only during the data phase of a read while cs_ni is low. It is 0 during the opcode and filler bytes and after cs_ni goes high.
- R8: prot_o[i] is 1 exactly when prot_en_i is 1 and sector i holds FFh. invalid_o[i] is 1 exactly when sector i holds a value other than 00h or FFh, whatever prot_en_i is.
- R9: A write updates the register whether prot_en_i is 0 or 1.
- R10: buf_dirty_o goes to 1 when a full write opcode has been received and stays 1 until reset. A read does not set it.
- R11: Bits of an incomplete byte that are pending when cs_ni goes high are dropped. The next transaction starts on a fresh byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| prot_en_i | input | 1 | Global protection enable |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output-enable for so_o |
| prot_o | output | NUM_SECT | Per-sector locked status |
| invalid_o | output | NUM_SECT | Per-sector invalid-value flag |
| buf_dirty_o | output | 1 | Sticky flag: buffer overwritten by a write command |

## Verification
The assertions assume that the serial clock is much slower than clk_i, so each serial level lasts at least a few system cycles after the synchronizer. They also assume that sck_i is low whenever cs_ni changes. The bench drives every serial edge on the falling edge of clk_i and holds each serial half-period for six system cycles. It toggles cs_ni only while sck_i is low, so every SCK edge is seen exactly once.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam logic [7:0] OP_RD   = 8'h32;
  localparam logic [7:0] OP_WR0  = 8'h3D;
  localparam logic [7:0] OP_WR1  = 8'h2A;
  localparam logic [7:0] OP_WR2  = 8'h7F;
  localparam logic [7:0] OP_WR3  = 8'hFC;
  localparam int unsigned FILLER_BYTES = 3;

  typedef enum logic [2:0] {
    ST_OP, ST_W1, ST_W2, ST_W3, ST_WDATA, ST_FILL, ST_RDATA, ST_SKIP
  } spr_state_e;
endpackage

// File: rtl/spr_in_sync.sv
module spr_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic cs_hi_o,
  output logic cs_rise_o,
  output logic si_o,
  output logic sck_rise_o,
  output logic sck_fall_o
);
  logic [STAGES-1:0] cs_r, sck_r, si_r;
  logic cs_d, sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_r  <= '1;
      sck_r <= '0;
      si_r  <= '0;
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_r  <= {cs_r[STAGES-2:0], cs_ni};
      sck_r <= {sck_r[STAGES-2:0], sck_i};
      si_r  <= {si_r[STAGES-2:0], si_i};
      cs_d  <= cs_r[STAGES-1];
      sck_d <= sck_r[STAGES-1];
    end
  end

  assign cs_hi_o    = cs_r[STAGES-1];
  assign cs_rise_o  = cs_r[STAGES-1] & ~cs_d;
  assign si_o       = si_r[STAGES-1];
  assign sck_rise_o = sck_r[STAGES-1] & ~sck_d;
  assign sck_fall_o = ~sck_r[STAGES-1] & sck_d;
endmodule

// File: rtl/spr_byte_rx.sv
module spr_byte_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       rise_i,
  input  logic       si_i,
  output logic [7:0] byte_o,
  output logic       valid_o
);
  logic [6:0] sh_q;
  logic [2:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;   // drop partial byte
      cnt_q <= '0;
    end else if (rise_i) begin
      sh_q  <= {sh_q[5:0], si_i};
      cnt_q <= cnt_q + 3'd1;
    end
  end

  assign byte_o  = {sh_q, si_i};
  assign valid_o = rise_i & ~clr_i & (cnt_q == 3'd7);
endmodule

// File: rtl/spr_tx_shift.sv
module spr_tx_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       fall_i,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic       need_o,
  output logic       so_o
);
  logic [6:0] sh_q;
  logic [2:0] bit_q;
  logic       so_q;
  logic       step;

  assign step   = fall_i & en_i & ~clr_i;
  assign need_o = step & (bit_q == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= '0;
      so_q  <= 1'b0;
    end else if (clr_i) begin
      sh_q  <= '0;
      bit_q <= '0;
      so_q  <= 1'b0;
    end else if (need_o) begin
      so_q  <= byte_i[7];
      sh_q  <= byte_i[6:0];
      bit_q <= 3'd1;
    end else if (step) begin
      so_q  <= sh_q[6];
      sh_q  <= {sh_q[5:0], 1'b0};
      bit_q <= bit_q + 3'd1;
    end
  end

  assign so_o = so_q;

  a_r2_so_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_q != $past(so_q)) |-> $past(fall_i || clr_i));
endmodule

// File: rtl/spr_spi_prot.sv
module spr_spi_prot
  import spr_pkg::*;
#(
  parameter int unsigned NUM_SECT    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                sck_i,
  input  logic                si_i,
  input  logic                prot_en_i,
  output logic                so_o,
  output logic                so_oe_o,
  output logic [NUM_SECT-1:0] prot_o,
  output logic [NUM_SECT-1:0] invalid_o,
  output logic                buf_dirty_o
);
  localparam int unsigned IW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam logic [IW-1:0] LAST_W = IW'(NUM_SECT - 1);
  localparam logic [IW:0]   END_R  = (IW+1)'(NUM_SECT);
  localparam logic [1:0]    LAST_F = 2'(FILLER_BYTES - 1);

  logic cs_hi, cs_rise, si_s, sck_rise, sck_fall;
  logic [7:0] rx_byte, tx_byte;
  logic rx_v, tx_need;

  spr_state_e state_q;
  logic [NUM_SECT-1:0][7:0] reg_q, shadow_q;
  logic [IW-1:0] widx_q;
  logic [IW:0]   ridx_q;
  logic [1:0]    fcnt_q;
  logic          dirty_q, oe_q;

  spr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .cs_hi_o(cs_hi), .cs_rise_o(cs_rise), .si_o(si_s),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall)
  );

  spr_byte_rx u_rx (
    .clk_i, .rst_ni, .clr_i(cs_hi), .rise_i(sck_rise), .si_i(si_s),
    .byte_o(rx_byte), .valid_o(rx_v)
  );

  assign tx_byte = (ridx_q < END_R) ? reg_q[ridx_q[IW-1:0]] : 8'h00;

  spr_tx_shift u_tx (
    .clk_i, .rst_ni, .clr_i(cs_hi), .fall_i(sck_fall),
    .en_i(state_q == ST_RDATA), .byte_i(tx_byte),
    .need_o(tx_need), .so_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OP;
      reg_q    <= '0;
      shadow_q <= '0;
      widx_q   <= '0;
      ridx_q   <= '0;
      fcnt_q   <= '0;
      dirty_q  <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      oe_q <= ~cs_hi & (state_q == ST_RDATA);
      if (tx_need && ridx_q != END_R) ridx_q <= ridx_q + 1'b1;
      if (cs_rise && state_q == ST_WDATA) reg_q <= shadow_q;  // commit on release
      if (cs_hi) begin
        state_q <= ST_OP;
      end else if (rx_v) begin
        unique case (state_q)
          ST_OP: begin
            if (rx_byte == OP_WR0) state_q <= ST_W1;
            else if (rx_byte == OP_RD) begin
              state_q <= ST_FILL;
              fcnt_q  <= '0;
            end else state_q <= ST_SKIP;
          end
          ST_W1: state_q <= (rx_byte == OP_WR1) ? ST_W2 : ST_SKIP;
          ST_W2: state_q <= (rx_byte == OP_WR2) ? ST_W3 : ST_SKIP;
          ST_W3: begin
            if (rx_byte == OP_WR3) begin
              state_q  <= ST_WDATA;
              shadow_q <= reg_q;
              widx_q   <= '0;
              dirty_q  <= 1'b1;
            end else state_q <= ST_SKIP;
          end
          ST_WDATA: begin
            shadow_q[widx_q] <= rx_byte;
            widx_q <= (widx_q == LAST_W) ? '0 : widx_q + 1'b1;
          end
          ST_FILL: begin
            if (fcnt_q == LAST_F) begin
              state_q <= ST_RDATA;
              ridx_q  <= '0;
            end else fcnt_q <= fcnt_q + 2'd1;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
    assign prot_o[i]    = prot_en_i & (reg_q[i] == 8'hFF);
    assign invalid_o[i] = (reg_q[i] != 8'hFF) & (reg_q[i] != 8'h00);
  end

  assign so_oe_o     = oe_q;
  assign buf_dirty_o = dirty_q;

  a_r3_commit_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_q != $past(reg_q)) |-> $past(cs_hi));
  a_r4_widx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    widx_q <= LAST_W);
  a_r6_ridx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ridx_q <= END_R);
  a_r7_oe_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> (state_q == ST_RDATA));
  a_r10_dirty_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(buf_dirty_o));
endmodule

// File: tb/tb_spr_spi_prot.sv
module tb_spr_spi_prot;
  localparam int NS = 4;
  localparam int H  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, prot_en = 1'b0;
  logic so, oe, dirty;
  logic [NS-1:0] prot, inval;
  int checks = 0, errors = 0;
  logic [7:0] exp_m [NS];

  always #4 clk = ~clk;

  spr_spi_prot #(.NUM_SECT(NS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .prot_en_i(prot_en), .so_o(so), .so_oe_o(oe), .prot_o(prot),
    .invalid_o(inval), .buf_dirty_o(dirty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start();
    cs_n = 1'b0; wait_n(H);
  endtask

  task automatic stop();
    sck = 1'b0; wait_n(H); cs_n = 1'b1; wait_n(16);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
    rx = '0; oe_any = 1'b0;
    for (int b = 7; b >= 0; b--) begin
      si = tx[b];
      wait_n(H);
      rx = {rx[6:0], so};
      oe_any = oe_any | oe;
      sck = 1'b1; wait_n(H); sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r; logic o;
    xfer(tx, r, o);
  endtask

  task automatic bits(input int n);
    for (int b = 0; b < n; b++) begin
      si = 1'b1; wait_n(H); sck = 1'b1; wait_n(H); sck = 1'b0;
    end
  endtask

  task automatic wr_hdr();
    send(8'h3D); send(8'h2A); send(8'h7F); send(8'hFC);
  endtask

  task automatic check_status(input string tag);
    logic [NS-1:0] ep, ei;
    for (int i = 0; i < NS; i++) begin
      ep[i] = prot_en && exp_m[i] == 8'hFF;
      ei[i] = exp_m[i] != 8'hFF && exp_m[i] != 8'h00;
    end
    chk({tag, " R8 prot"}, 32'(prot), 32'(ep));
    chk({tag, " R8 invalid"}, 32'(inval), 32'(ei));
  endtask

  task automatic read_check(input string tag);
    logic [7:0] r; logic o;
    start();
    xfer(8'h32, r, o);
    chk({tag, " R7 oe during opcode"}, 32'(o), 0);
    for (int d = 0; d < 3; d++) begin
      xfer(8'hA5 ^ 8'(d * 8'h3C), r, o);
      chk({tag, " R7 oe during filler"}, 32'(o), 0);
    end
    for (int k = 0; k < NS + 2; k++) begin
      xfer(8'h00, r, o);
      chk({tag, " R7 oe in data"}, 32'(o), 1);
      chk({tag, " R6 R2 read byte"}, 32'(r), (k < NS) ? 32'(exp_m[k]) : 0);
    end
    stop();
    chk({tag, " R7 oe after release"}, 32'(oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r; logic o;
    logic [7:0] seq [4];
    for (int i = 0; i < NS; i++) exp_m[i] = 8'h00;
    wait_n(5); rst_n = 1'b1; wait_n(5);

    // R1 reset state
    chk("R1 prot", 32'(prot), 0);
    chk("R1 invalid", 32'(inval), 0);
    chk("R1 dirty", 32'(dirty), 0);
    chk("R1 oe", 32'(oe), 0);
    read_check("R1 reset read");
    chk("R10 read leaves dirty clear", 32'(dirty), 0);

    // R3 R4 R9 sweep of write lengths, alternating prot_en
    for (int n = 1; n <= NS + 3; n++) begin
      prot_en = n[0];
      start(); wr_hdr();
      chk("R10 dirty after opcode", 32'(dirty), 1);
      for (int k = 0; k < n; k++) begin
        logic [7:0] v;
        v = 8'((n * 29 + k * 71 + 5) & 255);
        exp_m[k % NS] = v;
        send(v);
      end
      stop();
      check_status("R9 sweep");
      read_check("R4 sweep");
    end

    // R8 valid encodings under both enable levels
    prot_en = 1'b1;
    start(); wr_hdr(); send(8'hFF); send(8'h00); send(8'hFF); send(8'h00); stop();
    exp_m[0] = 8'hFF; exp_m[1] = 8'h00; exp_m[2] = 8'hFF; exp_m[3] = 8'h00;
    check_status("R8 en");
    chk("R8 lock pattern", 32'(prot), 32'h5);
    prot_en = 1'b0; wait_n(2);
    check_status("R8 dis");

    // R3 no effect before release
    prot_en = 1'b1;
    start(); wr_hdr(); send(8'h00); send(8'hFF);
    wait_n(16);
    chk("R3 held until release", 32'(prot), 32'h5);
    stop();
    exp_m[0] = 8'h00; exp_m[1] = 8'hFF;
    chk("R3 after release", 32'(prot), 32'h6);
    check_status("R3");

    // R5 corrupt each opcode position
    seq[0] = 8'h3D; seq[1] = 8'h2A; seq[2] = 8'h7F; seq[3] = 8'hFC;
    for (int p = 0; p < 4; p++) begin
      logic oe_seen;
      oe_seen = 1'b0;
      start();
      for (int q = 0; q < 4; q++) begin
        xfer((q == p) ? (seq[q] ^ 8'h40) : seq[q], r, o);
        oe_seen |= o;
      end
      for (int k = 0; k < NS; k++) begin
        xfer(8'h11, r, o); oe_seen |= o;
      end
      stop();
      chk("R5 no oe on bad opcode", 32'(oe_seen), 0);
      check_status("R5");
    end
    read_check("R5 contents kept");

    // R11 partial bytes dropped
    start(); wr_hdr(); send(8'hC3); bits(5); stop();
    exp_m[0] = 8'hC3;
    check_status("R11");
    start(); bits(4); stop();
    read_check("R11 realigned");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule